// File: doc/BRIEF.md
# Serial Configuration Port for a Dual-Loop Synthesizer Core

This block is the control front end of a two-loop frequency synthesizer core. A controller sends 21-bit words over three pins: a serial clock, a serial data line and a latch strobe. The data line is sampled on each rising serial clock edge, most significant bit first. When the strobe rises, the word in the shift register is copied into one of four holding registers. The two bits shifted in last choose which one. Two of the holding registers carry the divider settings for the loops. The other two carry a per-loop mode field and a reference divider value.

The block turns the holding registers into plain output fields. For each loop these are a main divider, a swallow count, a reference divider, a power-off bit, phase-detector polarity, charge-pump tri-state and a 2-bit lock-detect source select. From the power-off bits it also builds the enable flags for the analog and counter blocks that sit around it. Powering a loop down turns off that loop's charge pump and RF input. Its reference divider stays on. Powering both loops down also turns off the reference dividers, the reference input buffer and the lock-detect output driver. The serial port itself is never gated.

All three serial pins are brought into the core clock domain through two-flop synchronizers, and all logic runs on the core clock.

Top module: `synth_ser_cfg`

## Requirements
- R1: Serial data is shifted into a 21-bit register on each rising edge of the serial clock. The first bit sent ends up as bit 20 (S20) and the last bit sent as bit 0 (S0).
- R2: On a rising edge of the latch strobe, the shift register is copied into the holding register whose index is {S1,S0}. No other holding register changes, and only one register is written per strobe.
- R3: Index 3 holds the loop 1 dividers and index 1 holds the loop 2 dividers. In each, the main divider is S20..S12 and the swallow count is S11..S7, with S11 as the MSB. Every swallow value from 0 to 31 appears unchanged at the output.
- R4: Index 2 holds the loop 1 mode word and index 0 holds the loop 2 mode word. Bit S11 is power-off (1 = off). S12 is phase-detector polarity (1 = normal, 0 = inverted). S13 is charge-pump tri-state (1 = high impedance). S15..S14 is the lock-detect source select.
- R5: In each mode word, S10..S2 is that loop's 9-bit reference divider value.
- R6: The test flag output equals S16 of the word last latched into index 0.
- R7: A loop that is powered off drops its charge-pump enable and its RF input enable. While at least one loop is on, both reference divider enables stay high.
- R8: When both loops are powered off, both reference divider enables, the reference input enable and the lock-detect output enable are low. Otherwise they are all high.
- R9: Shifting and latching keep working in every power-off combination, including both loops off.
- R10: Serial clock edges that occur while the latch strobe is high do not shift data. Latching does not clear the shift register, so a second strobe with no valid shifting in between latches the same word again.
- R11: After reset every holding register is zero. Every divider and mode output is then 0, and every enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_dat_i | input | 1 | Serial data pin, MSB first |
| ser_le_i | input | 1 | Latch strobe pin |
| l1_main_o | output | 9 | Loop 1 main divider |
| l1_swal_o | output | 5 | Loop 1 swallow count |
| l1_ref_o | output | 9 | Loop 1 reference divider |
| l1_off_o | output | 1 | Loop 1 power-off |
| l1_pd_norm_o | output | 1 | Loop 1 phase-detector polarity, 1 = normal |
| l1_cp_hiz_o | output | 1 | Loop 1 charge pump tri-state |
| l1_ld_sel_o | output | 2 | Loop 1 lock-detect source select |
| l2_main_o | output | 9 | Loop 2 main divider |
| l2_swal_o | output | 5 | Loop 2 swallow count |
| l2_ref_o | output | 9 | Loop 2 reference divider |
| l2_off_o | output | 1 | Loop 2 power-off |
| l2_pd_norm_o | output | 1 | Loop 2 phase-detector polarity, 1 = normal |
| l2_cp_hiz_o | output | 1 | Loop 2 charge pump tri-state |
| l2_ld_sel_o | output | 2 | Loop 2 lock-detect source select |
| l1_cp_en_o | output | 1 | Loop 1 charge-pump enable |
| l1_rfin_en_o | output | 1 | Loop 1 RF input enable |
| l2_cp_en_o | output | 1 | Loop 2 charge-pump enable |
| l2_rfin_en_o | output | 1 | Loop 2 RF input enable |
| ref1_en_o | output | 1 | Loop 1 reference divider enable |
| ref2_en_o | output | 1 | Loop 2 reference divider enable |
| refin_en_o | output | 1 | Reference input buffer enable |
| ld_out_en_o | output | 1 | Lock-detect output enable |
| test_flag_o | output | 1 | Test bit of the loop 2 mode word is set |

## Verification
A change on a serial pin reaches the second synchronizer flop at the second rising core clock edge. A shift, or a latch strobe rise, therefore takes effect in the shift register or holding register at that edge or the next one. The outputs are decoded combinationally from the holding registers, so every divider, mode and enable output is settled no later than the third core edge after the strobe rises. The bench keeps each serial clock phase for three core cycles and holds the strobe high for four. It samples all outputs on falling core edges at least four cycles after the strobe rises, so each check falls well after the result is due. Every check compares the full output set against a bench model of the four holding registers, which also shows that the registers not addressed stayed unchanged.

// File: rtl/synth_cfg_pkg.sv
// Package: shared widths, field positions and types for the serial
// configuration port. Assumes a 21-bit word whose two lowest bits select
// one of four holding registers.
package synth_cfg_pkg;
    localparam int WORD_W    = 21;
    localparam int ADDR_W    = 2;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int NUM_LOOPS = 2;
    localparam int MAIN_W    = 9;
    localparam int SWAL_W    = 5;
    localparam int REF_W     = 9;
    localparam int MODE_W    = 5;
    localparam int SWAL_LSB  = 7;
    localparam int MAIN_LSB  = SWAL_LSB + SWAL_W;
    localparam int REF_LSB   = ADDR_W;
    localparam int MODE_LSB  = REF_LSB + REF_W;
    localparam int TEST_BIT  = MODE_LSB + MODE_W;

    // Holding register indices, {S1,S0}
    typedef enum logic [ADDR_W-1:0] {
        IDX_L2_MODE = 2'b00,
        IDX_L2_DIV  = 2'b01,
        IDX_L1_MODE = 2'b10,
        IDX_L1_DIV  = 2'b11
    } reg_idx_e;

    // Mode field, bit 0 is power-off
    typedef struct packed {
        logic [1:0] ld_sel;
        logic       cp_hiz;
        logic       pd_norm;
        logic       off;
    } mode_t;
endpackage

// File: rtl/ser_front.sv
// Serial front end: synchronizes the serial clock, data and latch strobe
// into the core clock domain, shifts data MSB first on serial clock rises
// while the strobe is low, and emits a one-cycle latch pulse on a strobe
// rise. Assumes serial pins are slow relative to the core clock (each
// level held for at least three core cycles).
module ser_front #(
    parameter int WORD_W      = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    output logic [WORD_W-1:0] word,
    output logic              latch_stb
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sclk_s, dat_s, le_s;
    logic                   sclk_q, le_q;
    logic                   shift_en;
    logic [WORD_W-1:0]      sr;

    // Synchronizer chains and edge-detect history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= '0;
            dat_s  <= '0;
            le_s   <= '0;
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_s <= {sclk_s[SYNC_STAGES-2:0], ser_clk};
            dat_s  <= {dat_s[SYNC_STAGES-2:0], ser_dat};
            le_s   <= {le_s[SYNC_STAGES-2:0], ser_le};
            sclk_q <= sclk_s[TOP];
            le_q   <= le_s[TOP];
        end
    end

    // Shift only on a serial clock rise with the strobe low
    assign shift_en  = sclk_s[TOP] & ~sclk_q & ~le_s[TOP];
    assign latch_stb = le_s[TOP] & ~le_q;

    // Shift register, newest bit enters at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (shift_en)
            sr <= {sr[WORD_W-2:0], dat_s[TOP]};
    end

    assign word = sr;

    assert_le_blocks_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        le_s[TOP] |=> $stable(sr));
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> !latch_stb);
endmodule

// File: rtl/cfg_bank.sv
// Holding register bank: on a write pulse, stores the full word into the
// register indexed by its low ADDR_W bits. Assumes at most one write
// pulse per strobe (guaranteed by the front end).
module cfg_bank #(
    parameter int WORD_W   = 21,
    parameter int ADDR_W   = 2,
    parameter int NUM_REGS = 1 << ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [WORD_W-1:0]                wr_word,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs
);
    logic [ADDR_W-1:0] wr_addr;
    assign wr_addr = wr_word[ADDR_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        // One holding register, loaded only when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (hit)
                regs[i] <= wr_word;
        end

        assert_wr_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_word[ADDR_W-1:0] == ADDR_W'(i)) |=> regs[i] == $past(wr_word));
        assert_hold_other_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_word[ADDR_W-1:0] == ADDR_W'(i)) |=> $stable(regs[i]));
    end
endmodule

// File: rtl/loop_decode.sv
// Per-loop field decoder: slices the divider word and the mode word of one
// loop into its output fields. Pure combinational; assumes the field
// positions from synth_cfg_pkg.
module loop_decode
    import synth_cfg_pkg::*;
(
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] mode_word,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swal,
    output logic [REF_W-1:0]  ref_div,
    output mode_t             mode
);
    logic spare_bits_unused;

    // Field extraction
    always_comb begin
        main_div = div_word[MAIN_LSB +: MAIN_W];
        swal     = div_word[SWAL_LSB +: SWAL_W];
        ref_div  = mode_word[REF_LSB +: REF_W];
        mode     = mode_t'(mode_word[MODE_LSB +: MODE_W]);
    end

    // Bits that carry no field in this loop's words
    assign spare_bits_unused = ^{div_word[SWAL_LSB-1:0], mode_word[WORD_W-1:MODE_LSB+MODE_W],
                                 mode_word[REF_LSB-1:0]};
endmodule

// File: rtl/pwr_gate.sv
// Power-down qualification: turns per-loop power-off bits into enables.
// A loop that is off loses its charge pump and RF input. Only when every
// loop is off are the shared reference path and lock-detect driver
// dropped. The serial port is never gated here.
module pwr_gate #(
    parameter int NUM_LOOPS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LOOPS-1:0] loop_off,
    output logic [NUM_LOOPS-1:0] cp_en,
    output logic [NUM_LOOPS-1:0] rfin_en,
    output logic [NUM_LOOPS-1:0] ref_en,
    output logic                 refin_en,
    output logic                 ld_en
);
    logic all_off;

    // Shared-path gating when every loop is off
    always_comb begin
        all_off  = &loop_off;
        refin_en = ~all_off;
        ld_en    = ~all_off;
    end

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
        // Per-loop enables
        always_comb begin
            cp_en[i]   = ~loop_off[i];
            rfin_en[i] = ~loop_off[i];
            ref_en[i]  = ~all_off;
        end

        assert_ref_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rfin_en[i] |-> (ref_en[i] && refin_en));
    end

    assert_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !refin_en |-> (!ld_en && ref_en == '0 && cp_en == '0));
endmodule

// File: rtl/synth_ser_cfg.sv
// Top: serial configuration port for a two-loop synthesizer core. Chains
// the serial front end, the holding register bank, one decoder per loop
// and the power-down qualifier. Assumes loop 1 uses indices 3/2 and loop 2
// uses indices 1/0 (divider/mode).
module synth_ser_cfg
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_le_i,
    output logic [MAIN_W-1:0] l1_main_o,
    output logic [SWAL_W-1:0] l1_swal_o,
    output logic [REF_W-1:0]  l1_ref_o,
    output logic              l1_off_o,
    output logic              l1_pd_norm_o,
    output logic              l1_cp_hiz_o,
    output logic [1:0]        l1_ld_sel_o,
    output logic [MAIN_W-1:0] l2_main_o,
    output logic [SWAL_W-1:0] l2_swal_o,
    output logic [REF_W-1:0]  l2_ref_o,
    output logic              l2_off_o,
    output logic              l2_pd_norm_o,
    output logic              l2_cp_hiz_o,
    output logic [1:0]        l2_ld_sel_o,
    output logic              l1_cp_en_o,
    output logic              l1_rfin_en_o,
    output logic              l2_cp_en_o,
    output logic              l2_rfin_en_o,
    output logic              ref1_en_o,
    output logic              ref2_en_o,
    output logic              refin_en_o,
    output logic              ld_out_en_o,
    output logic              test_flag_o
);
    logic [WORD_W-1:0]                sr_word;
    logic                             latch_stb;
    logic [NUM_REGS-1:0][WORD_W-1:0]  regs;
    logic [NUM_LOOPS-1:0][MAIN_W-1:0] main_d;
    logic [NUM_LOOPS-1:0][SWAL_W-1:0] swal_d;
    logic [NUM_LOOPS-1:0][REF_W-1:0]  ref_d;
    mode_t [NUM_LOOPS-1:0]            mode_d;
    logic [NUM_LOOPS-1:0]             loop_off, cp_en, rfin_en, ref_en;

    ser_front #(.WORD_W(WORD_W), .SYNC_STAGES(2)) u_front (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk_i), .ser_dat(ser_dat_i), .ser_le(ser_le_i),
        .word(sr_word), .latch_stb(latch_stb)
    );

    cfg_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(latch_stb), .wr_word(sr_word), .regs(regs)
    );

    // Loop k (0-based) uses divider index 2k+1 and mode index 2k, reversed
    // so that loop 1 owns the upper pair
    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_dec
        localparam int DIV_IDX  = NUM_REGS - 1 - 2 * k;
        localparam int MODE_IDX = NUM_REGS - 2 - 2 * k;
        loop_decode u_dec (
            .div_word(regs[DIV_IDX]), .mode_word(regs[MODE_IDX]),
            .main_div(main_d[k]), .swal(swal_d[k]),
            .ref_div(ref_d[k]), .mode(mode_d[k])
        );
        assign loop_off[k] = mode_d[k].off;
    end

    pwr_gate #(.NUM_LOOPS(NUM_LOOPS)) u_pwr (
        .clk(clk), .rst_n(rst_n), .loop_off(loop_off),
        .cp_en(cp_en), .rfin_en(rfin_en), .ref_en(ref_en),
        .refin_en(refin_en_o), .ld_en(ld_out_en_o)
    );

    // Output mapping to named ports
    always_comb begin
        l1_main_o    = main_d[0];
        l1_swal_o    = swal_d[0];
        l1_ref_o     = ref_d[0];
        l1_off_o     = mode_d[0].off;
        l1_pd_norm_o = mode_d[0].pd_norm;
        l1_cp_hiz_o  = mode_d[0].cp_hiz;
        l1_ld_sel_o  = mode_d[0].ld_sel;
        l2_main_o    = main_d[1];
        l2_swal_o    = swal_d[1];
        l2_ref_o     = ref_d[1];
        l2_off_o     = mode_d[1].off;
        l2_pd_norm_o = mode_d[1].pd_norm;
        l2_cp_hiz_o  = mode_d[1].cp_hiz;
        l2_ld_sel_o  = mode_d[1].ld_sel;
        l1_cp_en_o   = cp_en[0];
        l1_rfin_en_o = rfin_en[0];
        l2_cp_en_o   = cp_en[1];
        l2_rfin_en_o = rfin_en[1];
        ref1_en_o    = ref_en[0];
        ref2_en_o    = ref_en[1];
        test_flag_o  = regs[IDX_L2_MODE][TEST_BIT];
    end
endmodule

// File: tb/synth_ser_cfg_test.sv
`timescale 1ns/1ps
module synth_ser_cfg_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [8:0] l1_main, l1_ref, l2_main, l2_ref;
    logic [4:0] l1_swal, l2_swal;
    logic l1_off, l1_pdn, l1_hiz, l2_off, l2_pdn, l2_hiz;
    logic [1:0] l1_ld, l2_ld;
    logic l1_cp, l1_rf, l2_cp, l2_rf, ref1, ref2, refin, ldout, tflag;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    logic [20:0] bank_m [4];

    always #5 clk = ~clk;

    synth_ser_cfg uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
        .l1_main_o(l1_main), .l1_swal_o(l1_swal), .l1_ref_o(l1_ref), .l1_off_o(l1_off),
        .l1_pd_norm_o(l1_pdn), .l1_cp_hiz_o(l1_hiz), .l1_ld_sel_o(l1_ld),
        .l2_main_o(l2_main), .l2_swal_o(l2_swal), .l2_ref_o(l2_ref), .l2_off_o(l2_off),
        .l2_pd_norm_o(l2_pdn), .l2_cp_hiz_o(l2_hiz), .l2_ld_sel_o(l2_ld),
        .l1_cp_en_o(l1_cp), .l1_rfin_en_o(l1_rf), .l2_cp_en_o(l2_cp), .l2_rfin_en_o(l2_rf),
        .ref1_en_o(ref1), .ref2_en_o(ref2), .refin_en_o(refin), .ld_out_en_o(ldout),
        .test_flag_o(tflag)
    );

    logic [64:0] act;
    assign act = {l1_main, l1_swal, l1_ref, l1_ld, l1_hiz, l1_pdn, l1_off,
                  l2_main, l2_swal, l2_ref, l2_ld, l2_hiz, l2_pdn, l2_off,
                  l1_cp, l1_rf, l2_cp, l2_rf, ref1, ref2, refin, ldout, tflag};

    // Expected outputs from the register model and the requirement field map
    function automatic logic [64:0] expect_all();
        logic [20:0] d1 = bank_m[3], m1 = bank_m[2], d2 = bank_m[1], m2 = bank_m[0];
        logic o1 = m1[11], o2 = m2[11];
        logic both = o1 & o2;
        return {d1[20:12], d1[11:7], m1[10:2], m1[15:14], m1[13], m1[12], o1,
                d2[20:12], d2[11:7], m2[10:2], m2[15:14], m2[13], m2[12], o2,
                ~o1, ~o1, ~o2, ~o2, ~both, ~both, ~both, ~both, m2[16]};
    endfunction

    task automatic check_all(input string tag);
        logic [64:0] e = expect_all();
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, e);
        end
    endtask

    task automatic check_bit(input string tag, input logic a, input logic e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, a, e);
        end
    endtask

    task automatic shift_word(input logic [20:0] w);
        for (int i = 20; i >= 0; i--) begin
            ser_dat = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_word(input logic [20:0] w);
        shift_word(w);
        strobe();
        bank_m[w[1:0]] = w;
    endtask

    // Divider word: main S20..S12, swallow S11..S7, index S1..S0
    function automatic logic [20:0] dw(input logic [8:0] mn, input logic [4:0] sw, input logic [1:0] ix);
        return {mn, sw, 5'd0, ix};
    endfunction
    // Mode word: test S16, {ld,hiz,pdn,off} S15..S11, ref S10..S2
    function automatic logic [20:0] mw(input logic t, input logic [4:0] md, input logic [8:0] rf, input logic [1:0] ix);
        return {4'd0, t, md, rf, ix};
    endfunction

    localparam logic [20:0] VEC [0:7] = '{
        {9'd100, 5'd3,  5'd0,     2'b11},
        {9'd200, 5'd17, 5'd0,     2'b01},
        {4'd0, 1'b0, 5'b10110, 9'd50,  2'b10},
        {4'd0, 1'b0, 5'b01010, 9'd75,  2'b00},
        {9'd511, 5'd31, 5'b10101, 2'b11},
        {9'd0,   5'd0,  5'd0,     2'b01},
        {4'b1111, 1'b0, 5'b11110, 9'd511, 2'b10},
        {9'd1,   5'd1,  5'd0,     2'b11}
    };

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) bank_m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R11 reset state");

        // Table walk: R1 bit order, R2 addressing, R3/R4/R5 fields
        for (int v = 0; v < 8; v++) begin
            write_word(VEC[v]);
            check_all($sformatf("R1 R2 R3 R4 R5 vector %0d", v));
        end

        // Swallow boundaries on loop 2 (R3)
        write_word(dw(9'd7, 5'd0, 2'b01));
        check_all("R3 swallow 0");
        write_word(dw(9'd7, 5'd31, 2'b01));
        check_all("R3 swallow 31");
        write_word(dw(9'd7, 5'd2, 2'b01));
        check_all("R3 swallow 2");

        // Test bit (R6)
        write_word(mw(1'b1, 5'b00010, 9'd3, 2'b00));
        check_bit("R6 test flag set", tflag, 1'b1);
        check_all("R6 full");
        write_word(mw(1'b0, 5'b00010, 9'd3, 2'b00));
        check_bit("R6 test flag clear", tflag, 1'b0);

        // Every power-off combination (R7, R8), port still live (R9)
        for (int c = 0; c < 4; c++) begin
            write_word(mw(1'b0, {4'b0010, c[0]}, 9'd20, 2'b10));
            write_word(mw(1'b0, {4'b0100, c[1]}, 9'd30, 2'b00));
            check_all($sformatf("R7 R8 power combo %0d", c));
            check_bit("R8 ref input enable", refin, ~(c[0] & c[1]));
            write_word(dw(9'(40 + c), 5'(c + 9), 2'b11));
            check_all($sformatf("R9 latch in power combo %0d", c));
        end

        // Shifts with strobe high are dropped; relatch gives the old word (R10)
        write_word(dw(9'd300, 5'd12, 2'b11));
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        shift_word(dw(9'd5, 5'd5, 2'b01));
        check_all("R10 strobe high shifting");
        ser_le = 1'b0;
        repeat (3) @(negedge clk);
        strobe();
        check_all("R10 relatch same word");

        // Mid-run reset (R11)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) bank_m[i] = '0;
        repeat (2) @(negedge clk);
        check_all("R11 reset after traffic");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule